// File: doc/BRIEF.md
# Linear Imager Readout Sequencer

This block is the digital switch control for a 102-element linear photodiode imager with a global hold. It has one clock and one serial start input. A start sampled high on a rising edge does three things at once. It freezes every pixel's sampled charge, which is the global hold. It opens a fixed integrator-reset window. It injects a one-hot token that then walks through the pixel-select positions, one per clock. While the token is inside the chain, the output is enabled and the selected pixel number is reported. When the token leaves the chain, the output returns to the modelled high-impedance condition.

The sequencer is a three-state machine. The states are `S_IDLE` (integrating, output off), `S_RST_RD` (integrators held in reset while readout runs) and `S_RD` (readout continues while the next integration runs). The transitions are:
- `T_START`: any state goes to `S_RST_RD` when start is sampled high.
- `T_WIN_END`: `S_RST_RD` goes to `S_RD` on the last clock of the reset window.
- `T_FRAME_END`: `S_RD` goes to `S_IDLE` on the clock that moves the token past the final pixel.

A start that arrives mid-frame restarts both the token and the reset window. The reset window must be shorter than the pixel count, which holds for the defaults (18 and 102).

Top module: `lsa_sequencer`

## Requirements
- R1: With `rst` sampled high at a rising edge, after that edge `out_en`, `pix_vld` and `hold_o` are 0, `pix_sel` is 0, `rst_active` is 0 and `integrating` is 1.
- R2: When `start_in` is sampled high at an edge during an idle period, `pix_sel` is 1 and `out_en` is 1 from that edge on.
- R3: While a frame runs with no new start, `pix_sel` increases by exactly one per clock, from 1 up to 102.
- R4: `rst_active` is 1 for exactly 18 clocks, starting at the edge that samples the start. `integrating` is always its complement.
- R5: `hold_o` is 1 in exactly the cycles where `out_en` is 1. It rises at the start edge and falls on the clearing clock.
- R6: The clock after pixel 102 is shown (the 103rd clock of the frame, counting the start edge) clears the chain: `out_en` goes to 0 and `pix_sel` goes to 0.
- R7: With no start and no frame in progress, the outputs stay idle: `out_en` is 0 and `pix_sel` is 0.
- R8: A start sampled during a running frame, including at pixel 102, restarts the token at pixel 1 and reopens the full 18-clock reset window.
- R9: `pix_vld` equals `out_en`. When `pix_vld` is high, `pix_sel` lies in 1..102. When it is low, `pix_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Serial start pulse, sampled on the rising edge |
| pix_sel | output | 7 | Selected pixel number, 1..102, or 0 when idle |
| pix_vld | output | 1 | Strobe: `pix_sel` names a pixel being output |
| out_en | output | 1 | Analog output driven (0 models high impedance) |
| hold_o | output | 1 | Global sample/hold disconnect is active |
| rst_active | output | 1 | Integrator-reset window is open |
| integrating | output | 1 | Pixels are integrating light |

## Verification
The bench builds the block with its defaults: 102 pixels and an 18-clock reset window. At these values a whole frame is only 103 clocks, so it can run complete frames from end to end. It covers a restart placed inside the reset window, a restart after the window has ended, a restart on the final pixel, a start held high for several clocks, and a reset in mid-frame. Each of these cases is compared clock by clock with a behavioural integer model.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RST_RD = 2'd1,
        S_RD     = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lsa_token_chain.sv
module lsa_token_chain #(
    parameter int NPIX = 102
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    output logic [NPIX-1:0] tok
);
    // One flop per pixel. A load places the token at position 0 and clears the rest.
    // The token that shifts out of the top position is dropped, which clears the chain.
    for (genvar i = 0; i < NPIX; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)       tok[i] <= 1'b0;
                else           tok[i] <= load;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || load) tok[i] <= 1'b0;
                else             tok[i] <= tok[i-1];
            end
        end
    end
endmodule

// File: rtl/lsa_onehot_index.sv
module lsa_onehot_index #(
    parameter int NPIX  = 102,
    parameter int IDX_W = $clog2(NPIX + 1)
) (
    input  logic [NPIX-1:0]  tok,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < NPIX; i++) begin
            if (tok[i]) idx = idx | IDX_W'(i + 1);
        end
    end
    assign any = |tok;
endmodule

// File: rtl/lsa_reset_timer.sv
module lsa_reset_timer #(
    parameter int RST_CYC = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic win_last
);
    localparam int CNT_W = $clog2(RST_CYC + 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= CNT_W'(RST_CYC);
        else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
    end

    assign win_last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/lsa_sequencer.sv
module lsa_sequencer #(
    parameter int NPIX    = 102,
    parameter int RST_CYC = 18,
    parameter int IDX_W   = $clog2(NPIX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    output logic [IDX_W-1:0] pix_sel,
    output logic             pix_vld,
    output logic             out_en,
    output logic             hold_o,
    output logic             rst_active,
    output logic             integrating
);
    import lsa_pkg::*;

    localparam int LAST = NPIX - 1;

    seq_state_e      state_q, state_d;
    logic [NPIX-1:0] tok;
    logic            tok_any;
    logic            win_last;
    logic            tok_last;

    lsa_token_chain #(.NPIX(NPIX)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .load (start_in),
        .tok  (tok)
    );

    lsa_onehot_index #(.NPIX(NPIX), .IDX_W(IDX_W)) u_enc (
        .tok (tok),
        .idx (pix_sel),
        .any (tok_any)
    );

    lsa_reset_timer #(.RST_CYC(RST_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (start_in),
        .win_last (win_last)
    );

    assign tok_last = tok[LAST];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Transitions: T_START, T_WIN_END, T_FRAME_END
    always_comb begin
        state_d = state_q;
        if (start_in) begin
            state_d = S_RST_RD;
        end else begin
            unique case (state_q)
                S_IDLE:   state_d = S_IDLE;
                S_RST_RD: if (win_last) state_d = S_RD;
                S_RD:     if (tok_last) state_d = S_IDLE;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rst_active  = (state_q == S_RST_RD);
        integrating = (state_q != S_RST_RD);
        hold_o      = (state_q != S_IDLE);
        out_en      = tok_any;
        pix_vld     = tok_any;
    end
endmodule

// File: rtl/lsa_sequencer_chk.sv
module lsa_sequencer_chk #(
    parameter int NPIX    = 102,
    parameter int IDX_W   = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start_in,
    input logic [IDX_W-1:0] pix_sel,
    input logic             pix_vld,
    input logic             out_en,
    input logic             hold_o,
    input logic             rst_active,
    input logic             integrating
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!out_en && !hold_o && integrating && !rst_active && pix_sel == 0));

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        start_in |=> (pix_sel == IDX_W'(1) && out_en));

    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && pix_sel < IDX_W'(NPIX) && !start_in)
            |=> (pix_sel == $past(pix_sel) + IDX_W'(1)));

    assert_window_opens_R4: assert property (@(posedge clk) disable iff (rst)
        start_in |=> (rst_active && !integrating));

    assert_integ_compl_R4: assert property (@(posedge clk) disable iff (rst)
        integrating != rst_active);

    assert_hold_tracks_oe_R5: assert property (@(posedge clk) disable iff (rst)
        hold_o == out_en);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (pix_sel == IDX_W'(NPIX) && !start_in) |=> (!out_en && pix_sel == 0));

    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (rst)
        (!out_en && !start_in) |=> !out_en);

    assert_vld_range_R9: assert property (@(posedge clk) disable iff (rst)
        pix_vld |-> (pix_sel >= IDX_W'(1) && pix_sel <= IDX_W'(NPIX) && out_en));

    assert_vld_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !pix_vld |-> (pix_sel == 0 && !out_en));
endmodule

bind lsa_sequencer lsa_sequencer_chk #(.NPIX(NPIX), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_in    (start_in),
    .pix_sel     (pix_sel),
    .pix_vld     (pix_vld),
    .out_en      (out_en),
    .hold_o      (hold_o),
    .rst_active  (rst_active),
    .integrating (integrating)
);

// File: tb/sim_lsa_sequencer.sv
module sim_lsa_sequencer;
    localparam int NPIX = 102;
    localparam int RCYC = 18;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_in = 1'b0;
    logic [6:0] pix_sel;
    logic       pix_vld, out_en, hold_o, rst_active, integrating;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Behavioural model state
    int    m_pos = 0;
    int    m_rc  = 0;
    bit    m_live = 1'b0;
    string m_tag = "R1";

    always #5 clk = ~clk;

    lsa_sequencer u0 (
        .clk(clk), .rst(rst), .start_in(start_in),
        .pix_sel(pix_sel), .pix_vld(pix_vld), .out_en(out_en),
        .hold_o(hold_o), .rst_active(rst_active), .integrating(integrating)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        m_live = 1'b1;
        if (rst) begin
            m_tag = "R1"; m_pos = 0; m_rc = 0;
        end else if (start_in) begin
            m_tag = (m_pos != 0) ? "R8" : "R2";
            m_pos = 1; m_rc = RCYC;
        end else begin
            if (m_pos == NPIX)     begin m_tag = "R6"; m_pos = 0; end
            else if (m_pos == 0)   m_tag = "R7";
            else                   begin m_tag = "R3"; m_pos++; end
            if (m_rc > 0) m_rc--;
        end
    end

    always @(negedge clk) begin
        if (m_live && !done) begin
            chk(m_tag, "pix_sel", int'(pix_sel), m_pos);
            chk(m_tag, "out_en", int'(out_en), int'(m_pos != 0));
            chk("R9", "pix_vld", int'(pix_vld), int'(m_pos != 0));
            chk("R5", "hold_o", int'(hold_o), int'(m_pos != 0));
            chk("R4", "rst_active", int'(rst_active), int'(m_rc > 0));
            chk("R4", "integrating", int'(integrating), int'(m_rc == 0));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        @(negedge clk); start_in = 1'b1;
        for (int i = 1; i < n; i++) @(negedge clk);
        @(negedge clk); start_in = 1'b0;
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(5);                 // R7: idle with no start
        pulse(1); idle(110);     // full frame: R2 R3 R4 R5 R6
        pulse(1); idle(10);      // restart inside reset window: R8
        pulse(1); idle(40);      // restart after window ended: R8
        pulse(1); idle(110);
        pulse(1); idle(100);     // restart on pixel 102: R8
        pulse(1); idle(110);
        pulse(4); idle(110);     // start held for several clocks
        pulse(1); idle(30);
        @(negedge clk); rst = 1'b1;   // mid-frame reset: R1
        @(negedge clk); rst = 1'b0;
        idle(5);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule